// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake-up

This block is a watchdog that counts pulses of its own slow clock-enable tick. The tick comes from a clock that keeps running while the processor core's main clock is stopped for sleep, so the watchdog still counts during sleep. When the count reaches its period, the outcome depends on the core's state. An awake core gets a one-cycle reset request. A sleeping core gets a one-cycle wake-up request and then carries on normally. In both cases an active-high "no time-out" status flag drops to 0.

The period is an 8-bit prescaler followed by a postscaler. A configuration select picks the postscaler ratio as a power of two from 1 to 128. A configuration "always on" bit forces the watchdog to run. When that bit is 0, a software enable bit decides whether it runs. That bit sits in a one-byte control register. Software uses a clear-watchdog strobe to restart the count. The enter-sleep strobe also restarts it and sets the status flag back to 1.

Top module: `wdog_core`

## Requirements
- R1: Each tick while enabled advances the count. Time-out happens on the tick that completes 2^PRE_W × 2^S ticks since the count was last zero, where S is `cfg_ratio_sel_i` (0 gives ratio 1, 7 gives ratio 128). Cycles without a tick do not advance the count.
- R2: A time-out while `asleep_i` is 0 raises `core_reset_req_o` for exactly one cycle, starting the cycle after the expiring tick. The count then restarts from zero.
- R3: A time-out while `asleep_i` is 1 raises `wake_req_o` for one cycle instead, and `core_reset_req_o` stays 0. The count runs at the same rate while asleep. The two requests are never high together.
- R4: `no_timeout_o` is 1 after reset and becomes 0 in the same cycle a request rises.
- R5: A `clr_wdog_i` pulse zeroes both counters, sets `no_timeout_o` to 1, and wins over a time-out falling on the same cycle. The ratio selection is not changed.
- R6: An `enter_sleep_i` pulse has the same effect as R5.
- R7: With `cfg_always_on_i` = 1 the watchdog runs no matter what the software enable bit holds.
- R8: With `cfg_always_on_i` = 0 the software enable bit alone controls running. While the watchdog is stopped, both counters are held at zero, so re-enabling it starts a full period.
- R9: The control register is read on `ctl_rdata_o` and written with `ctl_wr_i`/`ctl_wdata_i`. Only bit 0 (the software enable) exists, and it resets to 0. Bits 7..1 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog domain clock (keeps running during sleep) |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Slow count-enable tick |
| cfg_always_on_i | input | 1 | Configuration: watchdog forced on |
| cfg_ratio_sel_i | input | 3 | Configuration: postscaler ratio 2^S |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read data |
| clr_wdog_i | input | 1 | Clear-watchdog strobe |
| enter_sleep_i | input | 1 | Enter-sleep strobe |
| asleep_i | input | 1 | Core is asleep |
| core_reset_req_o | output | 1 | One-cycle reset request |
| wake_req_o | output | 1 | One-cycle wake-up request |
| no_timeout_o | output | 1 | Status: 1 = no time-out since last clear |

## Verification
A wrong internal count is only visible at the ports when a request fires: the request comes too early or too late by whole ticks, or it does not come at all. The reference model therefore runs many periods at several ratios and tick densities, and checks the outputs on every cycle. A fault in the enable or strobe priority shows up as an extra or a missing request within one period. A wrong sleep decision shows up as the wrong request line in the cycle right after the time-out. Register faults show up on the very next read.

// File: rtl/wdog_pkg.sv
// Package: shared types for the watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package wdog_pkg;
    // Outcome of an expiry, registered by the top module
    typedef enum logic [1:0] {
        EXP_NONE  = 2'd0,
        EXP_RESET = 2'd1,
        EXP_WAKE  = 2'd2
    } wdog_exp_e;
endpackage

// File: rtl/wdog_ctrl_reg.sv
// Module: wdog_ctrl_reg
// One-byte control register. Only bit 0 (software enable) is stored.
// The other bits read as zero and drop written data.
// Assumes: DW >= 2, single address, write takes effect at the next edge.
module wdog_ctrl_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          sw_en_o
);
    logic sw_en_q;
    logic wdata_unused_bits;

    // Holds the software enable bit, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)    sw_en_q <= 1'b0;
        else if (wr_i) sw_en_q <= wdata_i[0];
    end

    // Builds read data with the upper bits tied low
    always_comb begin
        rdata_o    = '0;
        rdata_o[0] = sw_en_q;
    end

    assign wdata_unused_bits = ^wdata_i[DW-1:1];
    assign sw_en_o           = sw_en_q;
endmodule

// File: rtl/wdog_prescaler.sv
// Module: wdog_prescaler
// Free-wrapping W-bit tick counter. wrap_o marks the step that rolls it over.
// Assumes: clear_i wins over step_i.
module wdog_prescaler #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic wrap_o
);
    logic [W-1:0] cnt_q;

    // Counts steps, zeroed on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (step_i)       cnt_q <= cnt_q + 1'b1;
    end

    assign wrap_o = step_i && (cnt_q == '1);
endmodule

// File: rtl/wdog_postscaler.sv
// Module: wdog_postscaler
// Counts prescaler wraps. last_o marks the wrap that finishes 2^sel wraps.
// Assumes: sel_i held steady between clears; clear_i wins over step_i.
module wdog_postscaler #(
    parameter int SEL_W = 3,
    localparam int POST_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             last_o
);
    logic [POST_W-1:0] cnt_q;
    logic [POST_W-1:0] term;

    // Terminal count (2^sel - 1) built bit by bit
    for (genvar g = 0; g < POST_W; g++) begin : g_term
        assign term[g] = (int'(sel_i) > g);
    end

    // Counts prescaler wraps, zeroed on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (step_i)       cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = step_i && (cnt_q >= term);
endmodule

// File: rtl/wdog_core.sv
// Module: wdog_core (top)
// Watchdog with sleep wake-up. Runs from clk, which keeps running during
// sleep, and advances on tick_i. On expiry it raises a one-cycle reset
// request when the core is awake, or a wake request when it is asleep.
// Assumes: strobes are single-cycle and synchronous to clk.
module wdog_core
    import wdog_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cfg_always_on_i,
    input  logic [SEL_W-1:0] cfg_ratio_sel_i,
    input  logic             ctl_wr_i,
    input  logic [DW-1:0]    ctl_wdata_i,
    output logic [DW-1:0]    ctl_rdata_o,
    input  logic             clr_wdog_i,
    input  logic             enter_sleep_i,
    input  logic             asleep_i,
    output logic             core_reset_req_o,
    output logic             wake_req_o,
    output logic             no_timeout_o
);
    logic      sw_en;
    logic      run;
    logic      restart;
    logic      pre_wrap;
    logic      post_last;
    logic      expire;
    logic      zero_cnt;
    wdog_exp_e exp_q;
    logic      flag_q;

    wdog_ctrl_reg #(.DW(DW)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr_i),
        .wdata_i (ctl_wdata_i),
        .rdata_o (ctl_rdata_o),
        .sw_en_o (sw_en)
    );

    assign run      = cfg_always_on_i || sw_en;
    assign restart  = clr_wdog_i || enter_sleep_i;
    assign expire   = post_last && !restart;
    assign zero_cnt = restart || !run || expire;

    wdog_prescaler #(.W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (zero_cnt),
        .step_i  (run && tick_i),
        .wrap_o  (pre_wrap)
    );

    wdog_postscaler #(.SEL_W(SEL_W)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (zero_cnt),
        .step_i  (pre_wrap),
        .sel_i   (cfg_ratio_sel_i),
        .last_o  (post_last)
    );

    // Registers the outcome of an expiry as a single-cycle request
    always_ff @(posedge clk) begin
        if (!rst_n)      exp_q <= EXP_NONE;
        else if (expire) exp_q <= asleep_i ? EXP_WAKE : EXP_RESET;
        else             exp_q <= EXP_NONE;
    end

    // Status flag: set by reset or a restart strobe, cleared by expiry
    always_ff @(posedge clk) begin
        if (!rst_n || restart) flag_q <= 1'b1;
        else if (expire)       flag_q <= 1'b0;
    end

    assign core_reset_req_o = (exp_q == EXP_RESET);
    assign wake_req_o       = (exp_q == EXP_WAKE);
    assign no_timeout_o     = flag_q;
endmodule

// File: rtl/wdog_checker.sv
// Module: wdog_checker
// Port-level properties of wdog_core, attached by bind.
// Assumes: the same parameters as the bound instance.
module wdog_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_always_on_i,
    input logic [DW-1:0] ctl_rdata_o,
    input logic          clr_wdog_i,
    input logic          enter_sleep_i,
    input logic          asleep_i,
    input logic          core_reset_req_o,
    input logic          wake_req_o,
    input logic          no_timeout_o
);
    p_req_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_reset_req_o && wake_req_o));
    p_reset_oneshot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset_req_o |=> !core_reset_req_o);
    p_wake_oneshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |=> !wake_req_o);
    p_reset_awake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset_req_o |-> !$past(asleep_i));
    p_wake_asleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> $past(asleep_i));
    p_flag_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_reset_req_o || wake_req_o) |-> !no_timeout_o);
    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wdog_i |=> (no_timeout_o && !core_reset_req_o && !wake_req_o));
    p_sleep_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        enter_sleep_i |=> (no_timeout_o && !core_reset_req_o && !wake_req_o));
    p_stopped_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_always_on_i && !ctl_rdata_o[0]) |=> (!core_reset_req_o && !wake_req_o));
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata_o[DW-1:1] == '0);
endmodule

bind wdog_core wdog_checker #(.DW(DW)) u_wdog_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_always_on_i  (cfg_always_on_i),
    .ctl_rdata_o      (ctl_rdata_o),
    .clr_wdog_i       (clr_wdog_i),
    .enter_sleep_i    (enter_sleep_i),
    .asleep_i         (asleep_i),
    .core_reset_req_o (core_reset_req_o),
    .wake_req_o       (wake_req_o),
    .no_timeout_o     (no_timeout_o)
);

// File: tb/test_wdog_core.sv
// Bench for wdog_core: a behavioural tick-count model checked every cycle,
// plus directed checks.
module test_wdog_core;
    localparam int PRE_W = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       aon = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       clr = 1'b0;
    logic       slp = 1'b0;
    logic       asleep = 1'b0;
    logic       rreq, wreq, flag;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int n_rst = 0;
    int n_wake = 0;

    // Reference model state
    int m_cnt = 0;
    bit m_sw = 0, m_flag = 1, m_rr = 0, m_wr = 0;

    always #4 clk = ~clk;

    wdog_core #(.PRE_W(PRE_W)) i_wdog_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .cfg_always_on_i(aon),
        .cfg_ratio_sel_i(sel), .ctl_wr_i(wr), .ctl_wdata_i(wdata),
        .ctl_rdata_o(rdata), .clr_wdog_i(clr), .enter_sleep_i(slp),
        .asleep_i(asleep), .core_reset_req_o(rreq), .wake_req_o(wreq),
        .no_timeout_o(flag)
    );

    // Model update: ticks counted since last zero, per the requirements
    always @(posedge clk) begin
        bit en, nsw;
        int lim;
        en  = aon || m_sw;
        nsw = wr ? wdata[0] : m_sw;
        lim = (1 << PRE_W) << sel;
        m_rr = 0; m_wr = 0;
        if (!rst_n) begin
            m_cnt = 0; m_flag = 1; nsw = 0;
        end else if (clr || slp) begin
            m_cnt = 0; m_flag = 1;
        end else if (!en) begin
            m_cnt = 0;
        end else if (tick) begin
            if (m_cnt + 1 == lim) begin
                m_cnt = 0; m_flag = 0;
                if (asleep) m_wr = 1; else m_rr = 1;
            end else m_cnt = m_cnt + 1;
        end
        m_sw = nsw;
        cycles++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
        end
    endtask

    // One clock, then compare all outputs with the model away from the edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        chk("R2 reset request", int'(rreq), int'(m_rr));
        chk("R3 wake request", int'(wreq), int'(m_wr));
        chk("R4 status flag", int'(flag), int'(m_flag));
        chk("R9 register read", int'(rdata), int'({7'd0, m_sw}));
        if (rreq) n_rst++;
        if (wreq) n_wake++;
    endtask

    task automatic run(input int n, input int every);
        for (int i = 0; i < n; i++) begin
            tick = (i % every) == 0;
            cyc();
        end
        tick = 1'b0;
    endtask

    task automatic pulse_clr();
        clr = 1'b1; cyc(); clr = 1'b0;
    endtask

    task automatic pulse_slp();
        slp = 1'b1; cyc(); slp = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] d);
        wr = 1'b1; wdata = d; cyc(); wr = 1'b0; wdata = 8'h00;
    endtask

    // Watchdog on the bench itself
    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        cyc();
        // R4 R9: reset state
        chk("R4 flag after reset", int'(flag), 1);
        chk("R9 enable after reset", int'(rdata), 0);

        // R8: stopped, no request for a long stretch
        n_rst = 0;
        run(100, 1);
        chk("R8 stopped makes no request", n_rst, 0);

        // R9: upper bits ignored
        wreg(8'hFE);
        chk("R9 upper bits read zero", int'(rdata), 0);
        wreg(8'hFF);
        chk("R9 bit0 set", int'(rdata), 1);

        // R1 R2: sel 0, tick each cycle -> 8 ticks per period
        n_rst = 0;
        run(8, 1);
        chk("R1 R2 one reset after 8 ticks", n_rst, 1);
        pulse_clr();
        chk("R5 flag restored by clear", int'(flag), 1);

        // R1: sel 2, sparse ticks -> 32 ticks, period 96 cycles
        sel = 3'd2; pulse_clr();
        n_rst = 0;
        run(96, 3);
        cyc();
        chk("R1 ratio 4 one reset", n_rst, 1);

        // R5: clears every 20 ticks prevent expiry
        n_rst = 0;
        for (int k = 0; k < 6; k++) begin
            run(20, 1);
            pulse_clr();
        end
        chk("R5 clears hold off time-out", n_rst, 0);

        // R8: disable then re-enable restarts a full period
        run(20, 1);
        wreg(8'h00);
        run(10, 1);
        wreg(8'h01);
        n_rst = 0;
        run(31, 1);
        chk("R8 re-enable restarts period", n_rst, 0);
        run(2, 1);
        chk("R8 full period after re-enable", n_rst, 1);

        // R6 R3: sleep strobe then sleeping expiry wakes
        sel = 3'd0;
        pulse_slp();
        asleep = 1'b1;
        n_rst = 0; n_wake = 0;
        run(8, 1);
        cyc();
        chk("R3 wake while asleep", n_wake, 1);
        chk("R3 no reset while asleep", n_rst, 0);
        asleep = 1'b0;

        // R6: sleep strobe on the expiring tick wins
        pulse_clr();
        run(7, 1);
        tick = 1'b1; slp = 1'b1; cyc(); slp = 1'b0; tick = 1'b0;
        chk("R6 sleep strobe beats expiry", int'(rreq), 0);

        // R7: always-on ignores software disable
        aon = 1'b1;
        wreg(8'h00);
        pulse_clr();
        n_rst = 0;
        run(40, 1);
        chk("R7 always-on runs with sw off", n_rst, 5);

        // R1: largest ratio, 1024 ticks
        sel = 3'd7; pulse_clr();
        n_rst = 0;
        run(1023, 1);
        chk("R1 ratio 128 not yet", n_rst, 0);
        run(1, 1);
        chk("R1 ratio 128 expires", n_rst, 1);

        // Mixed run: sleep toggling with ticks, model compare only
        sel = 3'd1;
        for (int k = 0; k < 8; k++) begin
            asleep = k[0];
            run(37, 2);
        end
        asleep = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule